// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This block is a small arithmetic peripheral that a microcontroller reaches over a plain register bus. Software places two 16-bit operands into the A and B registers. Once the programmed number of operand writes has arrived, the unit multiplies them. Depending on the mode bits, it then stores the product, adds it to a 40-bit accumulator, subtracts it from the accumulator, or stores its negation. The accumulator is read back as three 16-bit words.

A 16-bit control word holds the operating modes. It also carries a sticky overflow flag, a bit that stops results from reaching the accumulator, a self-clearing bit that wipes all data, and a square mode. In square mode a single operand write fills both operands and starts the operation at once.

The bus is synchronous. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. An operation runs on the clock edge after the write that triggers it.

Top module: `mul_acc_unit`

## Requirements
- R1: The register map is: control at address 0, operand A at 1, operand B at 2, and accumulator bits 15:0, 31:16 and 39:32 at addresses 3, 4 and 5. Any other address reads 0.
- R2: The control word has these bits:
  - bit 7: overflow flag (read-only)
  - bit 6: result-write suppress
  - bit 5: clear-all
  - bit 4: square
  - bit 3: wait-for-both
  - bit 2: subtract
  - bit 1: accumulate
  - bit 0: signed

  Bits 15:8 always read 0 and ignore writes. Bit 5 always reads 0.
- R3: After reset, the control word, both operands, the accumulator and the overflow flag are all 0.
- R4: The overflow flag clears on the edge where an operation is triggered. On the following edge it takes that operation's overflow result.
- R5: With result-write suppress set, the accumulator keeps its contents, while the overflow flag is still updated.
- R6: Writing 1 to clear-all zeroes both operands, the accumulator, the overflow flag and the operand write tracking on that same edge. Writing 0 to clear-all does nothing.
- R7: With square set, a write to A or B loads the value into both operands and triggers the operation. This holds whatever wait-for-both is set to.
- R8: With wait-for-both at 0, every operand write triggers an operation. With it at 1, an operation starts only once A and B have each been written, in either order. The tracking then restarts.
- R9: An operation triggered by a write on edge k updates the accumulator on edge k+1. Reads before edge k+1 return the old value.
- R10: The modes are selected by accumulate and subtract:

  | accumulate | subtract | result |
  |---|---|---|
  | 0 | 0 | product |
  | 1 | 0 | accumulator + product |
  | 1 | 1 | accumulator − product |
  | 0 | 1 | −product |

  When signed is 1, the operands and the product are two's complement. Otherwise they are unsigned.
- R11: Overflow is raised in these cases:
  - signed add or subtract: the 40-bit signed result overflows;
  - unsigned add: there is a carry out of bit 39;
  - unsigned subtract: there is a borrow;
  - any unsigned negate.
- R12: Operands read back as written. Bits 15:8 of the top accumulator word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |

## Verification
The internal state that can go wrong is the operand write tracking and the one-cycle pending-operation flag. A stale tracking bit appears at the ports as an accumulator that changes after a single write in wait-for-both mode, or that fails to change after the second write. This is visible two edges after the write. A misplaced result or overflow update appears directly in the accumulator words and in bit 7 of the control word one edge after the trigger. That is why every check reads the registers exactly one cycle after the triggering write. A long signed run that walks the accumulator up to its sign boundary exposes a wrong overflow rule on the 512th operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_OPA  = 1;
    localparam int ADDR_OPB  = 2;
    localparam int ADDR_ACC0 = 3;

    localparam int BIT_NOWR  = 6;
    localparam int BIT_CLR   = 5;

    typedef struct packed {
        logic nowr;   // suppress accumulator update
        logic sq;     // square mode
        logic both;   // wait for both operands
        logic sub;    // subtract / negate
        logic acc;    // accumulate
        logic sgn;    // signed operands
    } mode_t;

endpackage

// File: rtl/mac_regs.sv
module mac_regs
    import mac_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output mode_t             mode,
    output logic [DW-1:0]     op_a,
    output logic [DW-1:0]     op_b,
    output logic              clr,
    output logic              start,
    output logic              go
);

    typedef struct packed {
        mode_t         mode;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          seen_a;
        logic          seen_b;
        logic          go;
    } regs_t;

    regs_t s_d, s_q;
    logic  wr_ctrl, wr_a, wr_b;
    logic  seen_a_n, seen_b_n;
    logic  unused_hi;

    assign unused_hi = ^wr_data[DW-1:BIT_NOWR+1];
    assign wr_ctrl   = wr_en && (int'(addr) == ADDR_CTRL);
    assign wr_a      = wr_en && (int'(addr) == ADDR_OPA);
    assign wr_b      = wr_en && (int'(addr) == ADDR_OPB);

    always_comb begin
        s_d      = s_q;
        clr      = 1'b0;
        start    = 1'b0;
        seen_a_n = s_q.seen_a | wr_a;
        seen_b_n = s_q.seen_b | wr_b;
        if (wr_ctrl) begin
            s_d.mode = mode_t'({wr_data[BIT_NOWR], wr_data[BIT_CLR-1:0]});
            if (wr_data[BIT_CLR]) begin
                clr        = 1'b1;
                s_d.a      = '0;
                s_d.b      = '0;
                s_d.seen_a = 1'b0;
                s_d.seen_b = 1'b0;
            end
        end else if (wr_a || wr_b) begin
            if (s_q.mode.sq) begin
                s_d.a = wr_data;
                s_d.b = wr_data;
                start = 1'b1;
            end else begin
                if (wr_a) s_d.a = wr_data;
                else      s_d.b = wr_data;
                start = !s_q.mode.both || (seen_a_n && seen_b_n);
            end
            s_d.seen_a = start ? 1'b0 : seen_a_n;
            s_d.seen_b = start ? 1'b0 : seen_b_n;
        end
        s_d.go = start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode = s_q.mode;
    assign op_a = s_q.a;
    assign op_b = s_q.b;
    assign go   = s_q.go;

    AST_SQUARE_FILLS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_a || wr_b) && s_q.mode.sq) |=> (s_q.a == s_q.b)); // R7

    AST_CLEAR_DROPS_TRACKING: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!s_q.seen_a && !s_q.seen_b && !s_q.go)); // R6

    AST_TRACKING_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.seen_a && s_q.seen_b)); // R8

endmodule

// File: rtl/mac_arith.sv
module mac_arith
    import mac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ACC_W = 40
) (
    input  logic [DW-1:0]    op_a,
    input  logic [DW-1:0]    op_b,
    input  logic [ACC_W-1:0] acc_in,
    input  mode_t            mode,
    output logic [ACC_W-1:0] result,
    output logic             ovf
);

    localparam int PW  = 2 * DW;
    localparam int EXT = ACC_W - PW;
    localparam int MSB = ACC_W - 1;

    logic signed [PW-1:0] prod_s;
    logic        [PW-1:0] prod_u;
    logic [ACC_W-1:0]     p;
    logic [ACC_W:0]       sum_w;
    logic [ACC_W:0]       diff_w;

    always_comb begin
        prod_s = $signed(op_a) * $signed(op_b);
        prod_u = op_a * op_b;
        p      = mode.sgn ? {{EXT{prod_s[PW-1]}}, prod_s} : {{EXT{1'b0}}, prod_u};
        sum_w  = {1'b0, acc_in} + {1'b0, p};
        diff_w = {1'b0, acc_in} - {1'b0, p};
        result = p;
        ovf    = 1'b0;
        if (!mode.acc) begin
            if (mode.sub) begin
                result = '0 - p;
                ovf    = !mode.sgn;
            end
        end else if (mode.sub) begin
            result = diff_w[ACC_W-1:0];
            ovf    = mode.sgn ? ((acc_in[MSB] != p[MSB]) && (diff_w[MSB] != acc_in[MSB]))
                              : diff_w[ACC_W];
        end else begin
            result = sum_w[ACC_W-1:0];
            ovf    = mode.sgn ? ((acc_in[MSB] == p[MSB]) && (sum_w[MSB] != acc_in[MSB]))
                              : sum_w[ACC_W];
        end
    end

endmodule

// File: rtl/mul_acc_unit.sv
module mul_acc_unit
    import mac_pkg::*;
#(
    parameter int DW     = 16,
    parameter int ACC_W  = 40,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data
);

    localparam int NWORDS = (ACC_W + DW - 1) / DW;

    initial begin
        if (ACC_W <= 2 * DW || ADDR_ACC0 + NWORDS > (1 << ADDR_W))
            $error("mul_acc_unit: parameter set not supported");
    end

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             of;
    } st_t;

    st_t                    st_d, st_q;
    mode_t                  mode;
    logic [DW-1:0]          op_a, op_b;
    logic                   clr, start, go;
    logic [ACC_W-1:0]       result;
    logic                   ovf;
    logic [NWORDS*DW-1:0]   acc_pad;

    mac_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .mode(mode), .op_a(op_a), .op_b(op_b), .clr(clr), .start(start), .go(go)
    );

    mac_arith #(.DW(DW), .ACC_W(ACC_W)) u_arith (
        .op_a(op_a), .op_b(op_b), .acc_in(st_q.acc), .mode(mode),
        .result(result), .ovf(ovf)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (go) begin
                st_d.of = ovf;
                if (!mode.nowr) st_d.acc = result;
            end
            if (start) st_d.of = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        acc_pad              = '0;
        acc_pad[ACC_W-1:0]   = st_q.acc;
        rd_data              = '0;
        if (int'(addr) == ADDR_CTRL) begin
            rd_data[7:0] = {st_q.of, mode.nowr, 1'b0, mode.sq, mode.both,
                            mode.sub, mode.acc, mode.sgn};
        end else if (int'(addr) == ADDR_OPA) begin
            rd_data = op_a;
        end else if (int'(addr) == ADDR_OPB) begin
            rd_data = op_b;
        end else begin
            for (int i = 0; i < NWORDS; i++) begin
                if (int'(addr) == ADDR_ACC0 + i) rd_data = acc_pad[i*DW +: DW];
            end
        end
    end

    AST_CLEAR_WIPES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.acc == '0 && !st_q.of)); // R6

    AST_SUPPRESS_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (go && mode.nowr && !clr) |=> $stable(st_q.acc)); // R5

    AST_START_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clr) |=> !st_q.of); // R4

    AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !clr) |=> $stable(st_q.acc)); // R9

endmodule

// File: tb/sim_mul_acc_unit.sv
module sim_mul_acc_unit;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_OPA  = 3'd1;
    localparam logic [2:0] A_OPB  = 3'd2;
    localparam logic [2:0] A_ACC0 = 3'd3;
    localparam logic [2:0] A_ACC1 = 3'd4;
    localparam logic [2:0] A_ACC2 = 3'd5;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] a;
        logic [15:0] b;
        logic [39:0] acc;
        logic        of;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'h0028, 16'd3,    16'd5,    40'h000000000F, 1'b0}, // clear, unsigned mul
        '{16'h000A, 16'hFFFF, 16'hFFFF, 40'h00FFFE0010, 1'b0}, // unsigned mac
        '{16'h000E, 16'h0010, 16'h0002, 40'h00FFFDFFF0, 1'b0}, // unsigned msub
        '{16'h0029, 16'hFFFE, 16'd3,    40'hFFFFFFFFFA, 1'b0}, // clear, signed mul
        '{16'h000B, 16'h8000, 16'h8000, 40'h003FFFFFFA, 1'b0}, // signed mac
        '{16'h000D, 16'd7,    16'hFFFF, 40'h0000000007, 1'b0}, // signed negate
        '{16'h000C, 16'd2,    16'd3,    40'hFFFFFFFFFA, 1'b1}, // unsigned negate
        '{16'h0068, 16'd4,    16'd4,    40'h0000000000, 1'b0}, // clear, suppressed
        '{16'h000E, 16'd1,    16'd1,    40'hFFFFFFFFFF, 1'b1}, // borrow
        '{16'h000A, 16'd1,    16'd1,    40'h0000000000, 1'b1}, // carry
        '{16'h000A, 16'd2,    16'd2,    40'h0000000004, 1'b0}  // flag cleared again
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mul_acc_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_acc(output logic [39:0] v);
        logic [15:0] w0, w1, w2;
        rd(A_ACC0, w0);
        rd(A_ACC1, w1);
        rd(A_ACC2, w2);
        check("R12 top word pad", {24'd0, w2[15:8]}, 40'd0);
        v = {w2[7:0], w1, w0};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [39:0] acc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R3 reset state
        rd(A_CTRL, d); check("R3 ctrl", {24'd0, d}, 40'd0);
        rd(A_OPA, d);  check("R3 op A", {24'd0, d}, 40'd0);
        rd(A_OPB, d);  check("R3 op B", {24'd0, d}, 40'd0);
        rd_acc(acc);   check("R3 acc", acc, 40'd0);
        rd(3'd7, d);   check("R1 unmapped", {24'd0, d}, 40'd0);

        // R2 reserved bits and self-clearing clear bit
        wr(A_CTRL, 16'hFFFF);
        rd(A_CTRL, d); check("R2 ctrl readback", {24'd0, d}, 40'h5F);
        wr(A_CTRL, 16'h0020);
        rd(A_CTRL, d); check("R2 clear bit reads 0", {24'd0, d}, 40'h0);

        // R10 R11 R4 R5 vector table
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, VEC[i].ctrl);
            wr(A_OPA, VEC[i].a);
            wr(A_OPB, VEC[i].b);
            idle();
            rd_acc(acc);
            check($sformatf("R10 vector %0d acc", i), acc, VEC[i].acc);
            rd(A_CTRL, d);
            check($sformatf("R11 vector %0d flag", i), {39'd0, d[7]}, {39'd0, VEC[i].of});
        end

        // R8 single-write trigger
        wr(A_CTRL, 16'h0020);
        wr(A_CTRL, 16'h0000);
        wr(A_OPA, 16'd5); idle();
        rd_acc(acc); check("R8 trigger on A alone", acc, 40'd0);
        wr(A_OPB, 16'd6); idle();
        rd_acc(acc); check("R8 trigger on B alone", acc, 40'd30);

        // R8 wait-for-both
        wr(A_CTRL, 16'h0008);
        wr(A_OPA, 16'd2); idle();
        wr(A_OPA, 16'd3); idle();
        rd_acc(acc); check("R8 A twice no trigger", acc, 40'd30);
        wr(A_OPB, 16'd4); idle();
        rd_acc(acc); check("R8 both written", acc, 40'd12);
        wr(A_OPB, 16'd5); idle();
        rd_acc(acc); check("R8 tracking restarted", acc, 40'd12);
        wr(A_OPA, 16'd1); idle();
        rd_acc(acc); check("R8 B then A", acc, 40'd5);
        rd(A_OPA, d); check("R12 op A readback", {24'd0, d}, 40'd1);
        rd(A_OPB, d); check("R12 op B readback", {24'd0, d}, 40'd5);

        // R6 clear wipes operands and tracking
        wr(A_CTRL, 16'h0008);
        wr(A_OPA, 16'd7);
        wr(A_CTRL, 16'h0028);
        rd(A_OPA, d); check("R6 op A cleared", {24'd0, d}, 40'd0);
        rd(A_OPB, d); check("R6 op B cleared", {24'd0, d}, 40'd0);
        rd_acc(acc);  check("R6 acc cleared", acc, 40'd0);
        wr(A_OPB, 16'd3); idle();
        rd_acc(acc);  check("R6 tracking cleared", acc, 40'd0);
        wr(A_OPA, 16'd2); idle();
        rd_acc(acc);  check("R6 op after clear", acc, 40'd6);
        wr(A_CTRL, 16'h0008);
        rd_acc(acc);  check("R6 writing 0 no effect", acc, 40'd6);

        // R7 square overrides wait-for-both
        wr(A_CTRL, 16'h0038);
        wr(A_OPB, 16'd9); idle();
        rd(A_OPA, d); check("R7 A filled", {24'd0, d}, 40'd9);
        rd(A_OPB, d); check("R7 B filled", {24'd0, d}, 40'd9);
        rd_acc(acc);  check("R7 square result", acc, 40'd81);

        // R9 timing
        wr(A_CTRL, 16'h0030);
        wr(A_OPA, 16'd5);
        rd_acc(acc); check("R9 before result edge", acc, 40'd0);
        idle();
        rd_acc(acc); check("R9 after result edge", acc, 40'd25);

        // R5 suppress: flag updates, acc kept
        wr(A_CTRL, 16'h004C);
        wr(A_OPA, 16'd2);
        wr(A_OPB, 16'd3); idle();
        rd_acc(acc);  check("R5 acc kept", acc, 40'd25);
        rd(A_CTRL, d); check("R5 flag updated", {39'd0, d[7]}, 40'd1);

        // R11 signed overflow at the sign boundary
        wr(A_CTRL, 16'h0020);
        wr(A_CTRL, 16'h0013);
        for (int k = 0; k < 511; k++) begin
            wr(A_OPA, 16'h8000);
            idle();
        end
        rd_acc(acc);   check("R11 below boundary", acc, 40'h7FC0000000);
        rd(A_CTRL, d); check("R11 no flag yet", {39'd0, d[7]}, 40'd0);
        wr(A_OPA, 16'h8000); idle();
        rd_acc(acc);   check("R11 wrapped", acc, 40'h8000000000);
        rd(A_CTRL, d); check("R11 signed overflow", {39'd0, d[7]}, 40'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule